// File: doc/BRIEF.md
# Nibble-Mode Parallel Link Register Slave

This block is the device end of a narrow host link in which every byte on an 8-bit bus carries its own command. The top three bits of each byte give the operation: end and idle, select a register for writing, select a register for reading, or carry a data nibble. Bit 4 selects the upper bank of a 32-entry file of 4-bit registers, and the low four bits hold either a register number or a data nibble. Only nibbles travel. Writes come in on the bus, and reads go back on four status lines that the host samples.

A register write is a short sequence. The first write-select byte fixes the register. The next data byte commits its nibble, and the end code closes the sequence. Repeated bytes are harmless. Register 10 collects three hardware event flags that the host clears by writing ones. Register 11 masks them onto the interrupt output. Bit 2 of the upper-bank register 28 clears the whole register file.

Register 14 of the low bank is a byte-wide data port, not a storage cell. Reading 14, then 30, returns the low and then the high nibble of an external byte and advances that source. Writing to 14 opens a streaming mode. In this mode, nibble pairs are packed into bytes and offered on a valid/ready output.

Top module: `nibble_link_slave`

## Requirements
- R1: A bus byte is taken only in the cycle where `bus_stb` rises. Bits 7:5 = 111 is the end code, 010 is write-select, 110 is read-select and 000 is data. Any other code is ignored and leaves all state unchanged. Bit 4 is the bank bit, and bits 3:0 are the register number or the nibble.
- R2: The first write-select byte after any other command latches the register `{bit4, bits3:0}`. A later write-select byte does not change that register. The next data byte writes its bits 3:0 into the latched register, and the new value is readable from the following cycle.
- R3: After a commit, further data bytes leave the register unchanged until a new write-select arrives. An end code taken before any data byte commits nothing.
- R4: From the cycle after a read-select byte, `st_nib` shows the selected register, with register bit 0 on `st_nib[0]`. Outside the read-select state, `st_nib` is 0.
- R5: Read-selecting register 14 shows `port_rd_data[3:0]`, and read-selecting register 30 shows `port_rd_data[7:4]`. While register 30 is selected, the next accepted byte with a known code, other than a repeat of that same select, makes `port_rd_adv` high for exactly one cycle, starting the cycle after that byte.
- R6: Register 10 bits 0, 1 and 2 are set by `evt_tx_ok`, `evt_tx_err` and `evt_rx_ok`. Writing 1 to one of these bits clears it, but an event in the same cycle keeps it set. Bit 3 reads 0. `irq` is high when any of these bits is set together with the same bit of register 11.
- R7: A write that sets bit 2 of register 28 clears every register to 0 on the following clock edge.
- R8: If the latched write register is 14, the first data byte enters streaming mode. In that mode, a data byte with bit 4 clear stores its nibble as the low half. A data byte with bit 4 set completes `{high, low}` on `sb_data` with `sb_valid` only if a low half is pending, and is dropped otherwise. A byte stays valid and stable until `sb_ready`. Any other known command leaves streaming mode and discards a pending low half.
- R9: A stream byte completed while `sb_valid` is high and `sb_ready` is low is dropped.
- R10: After reset, every register is 0 and `st_nib`, `irq`, `sb_valid` and `port_rd_adv` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_data | input | 8 | Command/data byte from the host |
| bus_stb | input | 1 | Byte strobe; a byte is taken on its rising edge |
| st_nib | output | 4 | Read nibble returned on the host status lines |
| irq | output | 1 | Interrupt request |
| evt_tx_ok | input | 1 | Transmit-done event |
| evt_tx_err | input | 1 | Transmit-error event |
| evt_rx_ok | input | 1 | Receive-done event |
| port_rd_data | input | 8 | Current byte of the external read source |
| port_rd_adv | output | 1 | One-cycle advance pulse to the read source |
| sb_valid | output | 1 | Packed stream byte valid |
| sb_data | output | 8 | Packed stream byte |
| sb_ready | input | 1 | Consumer accepts the stream byte |

## Verification
The bound checker covers the cycle-level rules on every cycle. An end code returns the status lines to zero. An advance pulse lasts one cycle and follows an accepted byte. The interrupt rises only after an event or a bus byte. A stalled stream byte stays stable. A new stream byte appears only after a high-nibble data byte. Commit timing, the rule that repeated bytes are harmless, write-one-to-clear against a simultaneous event, the register-file clear and the drop rules for the stream all depend on whole byte sequences. The bench's scenarios check these against its behavioural model, and that model is compared with every output on every clock.

// File: rtl/nls_pkg.sv
// Shared types and command codes for the nibble-link register slave.
// Assumes the command field sits in the top three bits of each bus byte.
package nls_pkg;
    localparam logic [2:0] CMD_END  = 3'b111;
    localparam logic [2:0] CMD_WSEL = 3'b010;
    localparam logic [2:0] CMD_RSEL = 3'b110;
    localparam logic [2:0] CMD_DATA = 3'b000;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WSEL  = 3'd1,
        ST_WDONE = 3'd2,
        ST_STRM  = 3'd3,
        ST_RSEL  = 3'd4
    } seq_st_t;

    // True for the four command codes the link defines
    function automatic logic cmd_known(input logic [2:0] c);
        return (c == CMD_END) || (c == CMD_WSEL) || (c == CMD_RSEL) || (c == CMD_DATA);
    endfunction
endpackage

// File: rtl/nls_strobe_decode.sv
// Detects the strobe's rising edge and splits the bus byte into fields.
// Assumes bus_stb is synchronous to clk and data is stable while it is high.
module nls_strobe_decode #(
    parameter int NIB_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NIB_W+3:0]     bus_data,
    input  logic                 bus_stb,
    output logic                 byte_evt,
    output logic [2:0]           cmd,
    output logic                 bank,
    output logic [NIB_W-1:0]     nib
);
    localparam int BYTE_W = NIB_W + 4;

    logic stb_q;

    // Remember last strobe level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= 1'b0;
        else        stb_q <= bus_stb;
    end

    // Field extraction and one-cycle byte event
    always_comb begin
        byte_evt = bus_stb && !stb_q;
        cmd      = bus_data[BYTE_W-1 -: 3];
        bank     = bus_data[NIB_W];
        nib      = bus_data[NIB_W-1:0];
    end
endmodule

// File: rtl/nls_seq_fsm.sv
// Command sequencer: tracks write/read/stream state, latches the register
// address and emits commit, stream-nibble and port-advance controls.
// Assumes at most one byte event per cycle.
module nls_seq_fsm
    import nls_pkg::*;
#(
    parameter int NIB_W    = 4,
    parameter int PORT_IDX = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 byte_evt,
    input  logic [2:0]           cmd,
    input  logic                 bank,
    input  logic [NIB_W-1:0]     nib,
    output logic                 wr_en,
    output logic [NIB_W:0]       wr_addr,
    output logic [NIB_W-1:0]     wr_data,
    output logic                 rd_active,
    output logic [NIB_W:0]       rd_addr,
    output logic                 strm_evt,
    output logic                 strm_hi,
    output logic [NIB_W-1:0]     strm_nib,
    output logic                 strm_flush,
    output logic                 port_adv
);
    localparam int ADDR_W = NIB_W + 1;
    localparam logic [ADDR_W-1:0] PORT_LO = ADDR_W'(PORT_IDX);
    localparam logic [ADDR_W-1:0] PORT_HI = {1'b1, PORT_LO[ADDR_W-2:0]};

    seq_st_t           st_q, st_n;
    logic [ADDR_W-1:0] addr_q, addr_n;
    logic              adv_q, adv_n;
    logic [ADDR_W-1:0] addr_in;
    logic              known;

    assign addr_in = {bank, nib};
    assign known   = cmd_known(cmd);

    // State, latched address and advance pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            addr_q <= '0;
            adv_q  <= 1'b0;
        end else begin
            st_q   <= st_n;
            addr_q <= addr_n;
            adv_q  <= adv_n;
        end
    end

    // Next-state decode of one accepted byte
    always_comb begin
        st_n       = st_q;
        addr_n     = addr_q;
        adv_n      = 1'b0;
        wr_en      = 1'b0;
        strm_evt   = 1'b0;
        strm_flush = 1'b0;
        if (byte_evt && known) begin
            if (st_q == ST_RSEL && addr_q == PORT_HI &&
                !(cmd == CMD_RSEL && addr_in == PORT_HI))
                adv_n = 1'b1;
            if (st_q == ST_STRM && cmd != CMD_DATA)
                strm_flush = 1'b1;
            case (cmd)
                CMD_END: st_n = ST_IDLE;
                CMD_WSEL: begin
                    if (st_q != ST_WSEL) begin
                        st_n   = ST_WSEL;
                        addr_n = addr_in;
                    end
                end
                CMD_RSEL: begin
                    st_n   = ST_RSEL;
                    addr_n = addr_in;
                end
                default: begin
                    if (st_q == ST_WSEL) begin
                        if (addr_q == PORT_LO) begin
                            st_n     = ST_STRM;
                            strm_evt = 1'b1;
                        end else begin
                            st_n  = ST_WDONE;
                            wr_en = 1'b1;
                        end
                    end else if (st_q == ST_STRM) begin
                        strm_evt = 1'b1;
                    end
                end
            endcase
        end
    end

    // Output fields
    always_comb begin
        wr_addr   = addr_q;
        wr_data   = nib;
        rd_active = (st_q == ST_RSEL);
        rd_addr   = addr_q;
        strm_hi   = bank;
        strm_nib  = nib;
        port_adv  = adv_q;
    end
endmodule

// File: rtl/nls_regfile.sv
// Nibble register file with a write-one-to-clear event register, a mask
// register driving irq, and a control bit that clears the whole file.
// Assumes EVT_N <= NIB_W and distinct special indices.
module nls_regfile #(
    parameter int NIB_W   = 4,
    parameter int EVT_N   = 3,
    parameter int ISR_IDX = 10,
    parameter int IMR_IDX = 11,
    parameter int RST_IDX = 28,
    parameter int RST_BIT = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [NIB_W:0]       wr_addr,
    input  logic [NIB_W-1:0]     wr_data,
    input  logic [EVT_N-1:0]     evt,
    input  logic [NIB_W:0]       rd_addr,
    output logic [NIB_W-1:0]     rd_data,
    output logic                 irq
);
    localparam int ADDR_W = NIB_W + 1;
    localparam int REG_N  = 1 << ADDR_W;

    logic [NIB_W-1:0] regs_w [REG_N];
    logic             clr_all;

    assign clr_all = regs_w[RST_IDX][RST_BIT];

    for (genvar i = 0; i < REG_N; i++) begin : g_reg
        logic [NIB_W-1:0] q;
        logic             hit;
        assign hit       = wr_en && (wr_addr == ADDR_W'(i));
        assign regs_w[i] = q;
        if (i == ISR_IDX) begin : g_isr
            logic [EVT_N-1:0] clr_m;
            assign clr_m = hit ? wr_data[EVT_N-1:0] : '0;
            // Event flags: set by hardware, cleared by writing ones
            always_ff @(posedge clk) begin
                if (!rst_n)       q <= '0;
                else if (clr_all) q <= '0;
                else              q <= NIB_W'((q[EVT_N-1:0] & ~clr_m) | evt);
            end
        end else begin : g_plain
            // Plain storage nibble
            always_ff @(posedge clk) begin
                if (!rst_n)       q <= '0;
                else if (clr_all) q <= '0;
                else if (hit)     q <= wr_data;
            end
        end
    end

    // Read port and masked interrupt
    always_comb begin
        rd_data = regs_w[rd_addr];
        irq     = |(regs_w[ISR_IDX][EVT_N-1:0] & regs_w[IMR_IDX][EVT_N-1:0]);
    end
endmodule

// File: rtl/nls_nib_packer.sv
// Packs low/high stream nibbles into bytes on a one-entry valid/ready output.
// Assumes a completed byte is dropped when the output is stalled.
module nls_nib_packer #(
    parameter int NIB_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 strm_evt,
    input  logic                 strm_hi,
    input  logic [NIB_W-1:0]     strm_nib,
    input  logic                 strm_flush,
    input  logic                 sb_ready,
    output logic                 sb_valid,
    output logic [2*NIB_W-1:0]   sb_data
);
    logic [NIB_W-1:0] lo_q;
    logic             lo_vld;
    logic             emit, free;

    assign emit = strm_evt && strm_hi && lo_vld;
    assign free = !sb_valid || sb_ready;

    // Pending low half
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q   <= '0;
            lo_vld <= 1'b0;
        end else if (strm_flush) begin
            lo_vld <= 1'b0;
        end else if (strm_evt) begin
            if (!strm_hi) begin
                lo_q   <= strm_nib;
                lo_vld <= 1'b1;
            end else begin
                lo_vld <= 1'b0;
            end
        end
    end

    // Output holding register with handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sb_valid <= 1'b0;
            sb_data  <= '0;
        end else if (emit && free) begin
            sb_valid <= 1'b1;
            sb_data  <= {strm_nib, lo_q};
        end else if (sb_valid && sb_ready) begin
            sb_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/nibble_link_slave.sv
// Top of the nibble-link register slave: byte decode, sequencer, register
// file, stream packer and the status-line read mux.
// Assumes a synchronous host strobe and an external byte source for reads.
module nibble_link_slave #(
    parameter int NIB_W    = 4,
    parameter int PORT_IDX = 14,
    parameter int ISR_IDX  = 10,
    parameter int IMR_IDX  = 11,
    parameter int RST_IDX  = 28,
    parameter int RST_BIT  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NIB_W+3:0]     bus_data,
    input  logic                 bus_stb,
    output logic [NIB_W-1:0]     st_nib,
    output logic                 irq,
    input  logic                 evt_tx_ok,
    input  logic                 evt_tx_err,
    input  logic                 evt_rx_ok,
    input  logic [2*NIB_W-1:0]   port_rd_data,
    output logic                 port_rd_adv,
    output logic                 sb_valid,
    output logic [2*NIB_W-1:0]   sb_data,
    input  logic                 sb_ready
);
    localparam int ADDR_W = NIB_W + 1;
    localparam int EVT_N  = 3;
    localparam logic [ADDR_W-1:0] PORT_LO = ADDR_W'(PORT_IDX);
    localparam logic [ADDR_W-1:0] PORT_HI = {1'b1, PORT_LO[ADDR_W-2:0]};

    logic              byte_evt, bank;
    logic [2:0]        cmd;
    logic [NIB_W-1:0]  nib;
    logic              wr_en, rd_active, strm_evt, strm_hi, strm_flush;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [NIB_W-1:0]  wr_data, strm_nib, reg_rd;

    nls_strobe_decode #(.NIB_W(NIB_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_stb(bus_stb),
        .byte_evt(byte_evt), .cmd(cmd), .bank(bank), .nib(nib)
    );

    nls_seq_fsm #(.NIB_W(NIB_W), .PORT_IDX(PORT_IDX)) u_seq (
        .clk(clk), .rst_n(rst_n), .byte_evt(byte_evt), .cmd(cmd), .bank(bank),
        .nib(nib), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_active(rd_active), .rd_addr(rd_addr), .strm_evt(strm_evt),
        .strm_hi(strm_hi), .strm_nib(strm_nib), .strm_flush(strm_flush),
        .port_adv(port_rd_adv)
    );

    nls_regfile #(
        .NIB_W(NIB_W), .EVT_N(EVT_N), .ISR_IDX(ISR_IDX), .IMR_IDX(IMR_IDX),
        .RST_IDX(RST_IDX), .RST_BIT(RST_BIT)
    ) u_rf (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .evt({evt_rx_ok, evt_tx_err, evt_tx_ok}),
        .rd_addr(rd_addr), .rd_data(reg_rd), .irq(irq)
    );

    nls_nib_packer #(.NIB_W(NIB_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .strm_evt(strm_evt), .strm_hi(strm_hi),
        .strm_nib(strm_nib), .strm_flush(strm_flush), .sb_ready(sb_ready),
        .sb_valid(sb_valid), .sb_data(sb_data)
    );

    // Status-line nibble: register, data-port half, or zero when idle
    always_comb begin
        if (!rd_active)             st_nib = '0;
        else if (rd_addr == PORT_LO) st_nib = port_rd_data[NIB_W-1:0];
        else if (rd_addr == PORT_HI) st_nib = port_rd_data[2*NIB_W-1:NIB_W];
        else                         st_nib = reg_rd;
    end
endmodule

// File: rtl/nls_checker.sv
// Port-level temporal checks for nibble_link_slave, bound to the top.
// Assumes the same clock and synchronous active-low reset as the design.
module nls_checker #(
    parameter int NIB_W = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NIB_W+3:0]     bus_data,
    input logic                 bus_stb,
    input logic [NIB_W-1:0]     st_nib,
    input logic                 irq,
    input logic                 evt_tx_ok,
    input logic                 evt_tx_err,
    input logic                 evt_rx_ok,
    input logic                 port_rd_adv,
    input logic                 sb_valid,
    input logic [2*NIB_W-1:0]   sb_data,
    input logic                 sb_ready
);
    localparam int BYTE_W = NIB_W + 4;

    logic stb_d, edge_now, evt_any, is_end, is_hi_data;

    // Own copy of the strobe level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) stb_d <= 1'b0;
        else        stb_d <= bus_stb;
    end

    assign edge_now   = bus_stb && !stb_d;
    assign evt_any    = evt_tx_ok || evt_tx_err || evt_rx_ok;
    assign is_end     = bus_data[BYTE_W-1 -: 3] == 3'b111;
    assign is_hi_data = (bus_data[BYTE_W-1 -: 3] == 3'b000) && bus_data[NIB_W];

    p_end_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_now && is_end) |=> (st_nib == '0));

    p_adv_follows_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        port_rd_adv |-> $past(edge_now));

    p_adv_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        port_rd_adv |=> !port_rd_adv);

    p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(evt_any || edge_now));

    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_valid && !sb_ready) |=> (sb_valid && $stable(sb_data)));

    p_emit_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sb_valid) |-> $past(edge_now && is_hi_data));

    p_reset_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!sb_valid && !irq && !port_rd_adv && st_nib == '0));
endmodule

bind nibble_link_slave nls_checker #(.NIB_W(NIB_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_stb(bus_stb),
    .st_nib(st_nib), .irq(irq), .evt_tx_ok(evt_tx_ok), .evt_tx_err(evt_tx_err),
    .evt_rx_ok(evt_rx_ok), .port_rd_adv(port_rd_adv), .sb_valid(sb_valid),
    .sb_data(sb_data), .sb_ready(sb_ready)
);

// File: tb/nibble_link_slave_bench.sv
module nibble_link_slave_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_data = 8'h00;
    logic       bus_stb = 1'b0;
    logic [3:0] st_nib;
    logic       irq;
    logic       evt_tx_ok = 1'b0, evt_tx_err = 1'b0, evt_rx_ok = 1'b0;
    logic [7:0] port_rd_data = 8'h00;
    logic       port_rd_adv;
    logic       sb_valid;
    logic [7:0] sb_data;
    logic       sb_ready = 1'b0;

    int total = 0, bad = 0, cyc = 0, adv_cnt = 0;
    bit done = 0;
    byte got_q[$];

    nibble_link_slave u_nibble_link_slave (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_stb(bus_stb),
        .st_nib(st_nib), .irq(irq), .evt_tx_ok(evt_tx_ok), .evt_tx_err(evt_tx_err),
        .evt_rx_ok(evt_rx_ok), .port_rd_data(port_rd_data), .port_rd_adv(port_rd_adv),
        .sb_valid(sb_valid), .sb_data(sb_data), .sb_ready(sb_ready)
    );

    always #10 clk = ~clk;

    // ---------------- behavioural reference model ----------------
    int  m_mode;            // 0 idle, 1 write-select, 2 written, 3 stream, 4 read
    int  m_wa, m_ra;
    int  m_reg[32];
    bit  m_stb, m_have_lo, m_adv;
    int  m_lo;
    int  m_out[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_wa = 0; m_ra = 0; m_stb = 0; m_have_lo = 0; m_adv = 0;
            m_lo = 0; m_out.delete();
            foreach (m_reg[k]) m_reg[k] = 0;
        end else begin
            automatic bit stb_edge = bus_stb && !m_stb;
            automatic int c = bus_data[7:5];
            automatic int a = bus_data[4:0];
            automatic int n = bus_data[3:0];
            automatic bit hi = bus_data[4];
            automatic bit wr = 0;
            automatic int wa = 0, wd = 0;
            automatic bit held = m_out.size() != 0;
            m_stb = bus_stb;
            m_adv = 0;
            if (held && sb_ready) void'(m_out.pop_front());
            if (stb_edge && (c == 7 || c == 2 || c == 6 || c == 0)) begin
                if (m_mode == 4 && m_ra == 30 && !(c == 6 && a == 30)) m_adv = 1;
                if (m_mode == 3 && c != 0) m_have_lo = 0;
                if (c == 7) m_mode = 0;
                else if (c == 2) begin
                    if (m_mode != 1) begin m_mode = 1; m_wa = a; end
                end else if (c == 6) begin
                    m_mode = 4; m_ra = a;
                end else if (m_mode == 1 || m_mode == 3) begin
                    if (m_mode == 1 && m_wa != 14) begin
                        wr = 1; wa = m_wa; wd = n; m_mode = 2;
                    end else begin
                        m_mode = 3;
                        if (!hi) begin m_lo = n; m_have_lo = 1; end
                        else if (m_have_lo) begin
                            m_have_lo = 0;
                            if (m_out.size() == 0) m_out.push_back(n * 16 + m_lo);
                        end
                    end
                end
            end
            if ((m_reg[28] & 4) != 0) begin
                foreach (m_reg[k]) m_reg[k] = 0;
            end else begin
                automatic int clr = (wr && wa == 10) ? (wd & 7) : 0;
                automatic int ev = (evt_rx_ok ? 4 : 0) | (evt_tx_err ? 2 : 0) | (evt_tx_ok ? 1 : 0);
                m_reg[10] = ((m_reg[10] & ~clr) | ev) & 7;
                if (wr && wa != 10) m_reg[wa] = wd;
            end
        end
    end

    function automatic int exp_st();
        if (m_mode != 4) return 0;
        if (m_ra == 14) return port_rd_data[3:0];
        if (m_ra == 30) return port_rd_data[7:4];
        return m_reg[m_ra];
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison against the model, away from the clock edge
    always @(negedge clk) begin
        #5;
        if (rst_n && !done) begin
            chk("R4 st_nib vs model", st_nib, exp_st());
            chk("R6 irq vs model", irq, ((m_reg[10] & m_reg[11] & 7) != 0) ? 1 : 0);
            chk("R8 sb_valid vs model", sb_valid, m_out.size() != 0 ? 1 : 0);
            if (m_out.size() != 0) chk("R8 sb_data vs model", sb_data, m_out[0]);
            chk("R5 port_rd_adv vs model", port_rd_adv, m_adv);
        end
    end

    // Observation monitors
    always @(posedge clk) begin
        cyc++;
        if (rst_n && port_rd_adv) adv_cnt++;
        if (rst_n && sb_valid && sb_ready) got_q.push_back(sb_data);
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic send(input logic [7:0] b);
        @(negedge clk); bus_data = b; bus_stb = 1'b1;
        @(negedge clk); bus_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [3:0] v);
        send({3'b111, a}); send({3'b010, a}); send({3'b010, a});
        send({3'b010, a[4], v}); send({3'b000, a[4], v}); send({3'b000, a[4], v});
        send({3'b111, a[4], v});
    endtask

    task automatic rd_reg(input logic [4:0] a, input int exp, input string tag);
        send({3'b110, a});
        #5 chk(tag, st_nib, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #5;
        chk("R10 reset st_nib", st_nib, 0);
        chk("R10 reset irq", irq, 0);
        chk("R10 reset sb_valid", sb_valid, 0);
        chk("R10 reset port_rd_adv", port_rd_adv, 0);
        @(negedge clk); rst_n = 1'b1;

        // r2_ basic low and high bank writes
        wr_reg(5'd3, 4'hA);
        rd_reg(5'd3, 'hA, "R2 low bank write");
        wr_reg(5'h15, 4'h6);
        rd_reg(5'h15, 'h6, "R2 high bank write");
        rd_reg(5'd7, 0, "R10 untouched register zero");
        send(8'hE0);
        #5 chk("R4 idle after end", st_nib, 0);

        // r3_ repeated/late data bytes, and end before data
        send(8'hE6); send(8'h46); send(8'h46); send(8'h45); send(8'h05); send(8'h07); send(8'h0C);
        send(8'hE0);
        rd_reg(5'd6, 'h5, "R3 later data bytes ignored");
        send(8'hE4); send(8'h44); send(8'h49); send(8'hE9);
        rd_reg(5'd4, 0, "R3 end before data commits nothing");

        // r1_ strobe held high: no second byte; unknown code ignored
        send(8'hE5); send(8'h45);
        @(negedge clk); bus_data = 8'h45; bus_stb = 1'b1;
        @(negedge clk); bus_data = 8'h07;
        @(negedge clk); @(negedge clk); bus_stb = 1'b0;
        send(8'hE0);
        rd_reg(5'd5, 0, "R1 no byte without strobe edge");
        send(8'hE5); send(8'h45); send(8'h27); send(8'h09); send(8'hE0);
        rd_reg(5'd5, 'h9, "R1 unknown code ignored");

        // r6_ events, mask, write-one-to-clear, event wins
        @(negedge clk); evt_rx_ok = 1'b1; @(negedge clk); evt_rx_ok = 1'b0;
        rd_reg(5'd10, 'h4, "R6 event sets flag");
        #1 chk("R6 masked flag no irq", irq, 0);
        wr_reg(5'd11, 4'h4);
        #1 chk("R6 unmasked irq", irq, 1);
        wr_reg(5'd10, 4'hC);
        #1 chk("R6 write one clears", irq, 0);
        rd_reg(5'd10, 0, "R6 flag cleared and bit3 zero");
        @(negedge clk); evt_tx_ok = 1'b1;
        wr_reg(5'd10, 4'h1);
        @(negedge clk); evt_tx_ok = 1'b0;
        rd_reg(5'd10, 'h1, "R6 event wins over clear");

        // r5_ data port read and advance
        port_rd_data = 8'h5C;
        rd_reg(5'd14, 'hC, "R5 port low nibble");
        rd_reg(5'd30, 'h5, "R5 port high nibble");
        send(8'hDE);
        #1 chk("R5 repeat select no advance", adv_cnt, 0);
        port_rd_data = 8'h3B;
        send(8'hE0);
        #1 chk("R5 one advance after leaving", adv_cnt, 1);

        // r8_ r9_ streaming
        sb_ready = 1'b0;
        send(8'hEE); send(8'h4E); send(8'h4E); send(8'h03); send(8'h1A);
        #1 chk("R8 byte packed valid", sb_valid, 1);
        chk("R8 byte packed value", sb_data, 'hA3);
        send(8'h05); send(8'h16);
        #1 chk("R9 stalled output keeps old byte", sb_data, 'hA3);
        @(negedge clk); sb_ready = 1'b1;
        @(negedge clk);
        #1 chk("R8 byte taken", sb_valid, 0);
        chk("R8 one byte delivered", got_q.size(), 1);
        send(8'h17);
        #1 chk("R8 lone high nibble dropped", got_q.size(), 1);
        send(8'h01); send(8'h12); send(8'h03); send(8'h14);
        #1 chk("R8 word gives two bytes", got_q.size(), 3);
        if (got_q.size() == 3) begin
            chk("R8 word low byte", got_q[1], 'h21);
            chk("R8 word high byte", got_q[2], 'h43);
        end
        send(8'h05); send(8'hE0); send(8'h4E); send(8'h1B);
        #1 chk("R8 end discards pending low", got_q.size(), 3);
        send(8'hE0);

        // r7_ control clear
        wr_reg(5'd3, 4'h9);
        wr_reg(5'd28, 4'h4);
        rd_reg(5'd3, 0, "R7 clear wipes register 3");
        rd_reg(5'd28, 0, "R7 control bit self-clears");
        rd_reg(5'd11, 0, "R7 mask cleared");
        send(8'hE0);

        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule